// File: doc/BRIEF.md
# Multi-Size Compare Flag Unit

This block subtracts a source operand from a destination operand and turns the difference into condition flags. The operation names a data size for each compare: byte, word, long or full accumulator. The flags are always taken at that size's width, so one bit pattern can give different flags at different sizes. Operands come from two 36-bit accumulators, each a 4-bit extension above a 32-bit body. For long and full compares, a 16-bit register can replace the source accumulator.

A compatibility mode input tells full-accumulator compares to ignore the extension. In that mode a full compare gives its flags at 32 bits, and the two extension-related flags stay clear. The flags are registered when the valid strobe is high and keep their value at all other times.

Top module: `cc_compare_unit`

## Requirements
- R1: `size_i` selects the width: 0 = byte (8 bits), 1 = word (16), 2 = long (32), 3 = full (36). The result is always destination minus source.
- R2: A byte compare uses bits 7:0 of `dst_acc_i` and bits 7:0 of the source. The source is `src_reg_i` when `use_reg_i` is 1 and `src_acc_i` otherwise. Flags are taken at 8 bits.
- R3: A word compare uses bits 15:0 of the same operands as R2, and its flags are taken at 16 bits.
- R4: A long compare uses only bits 31:0 of each operand and ignores bits 35:32.
- R5: A full compare in normal mode (`compat_i` = 0) uses all 36 bits, extension included.
- R6: For long and full compares with `use_reg_i` = 1, the source is `src_reg_i` placed in bits 31:16, with bits 15:0 zero and bits 35:32 copying bit 15 of the register.
- R7: The flags are defined at the effective width W:
  - N is result bit W-1.
  - Z is 1 when result bits W-1:0 are all zero.
  - V is signed overflow of the subtraction.
  - C is 1 when the destination is below the source, both taken as unsigned W-bit values.
- R8: With `compat_i` = 1, a full compare computes N, Z, V and C at 32 bits, exactly as a long compare does.
- R9: E and U are set only by a full compare with `compat_i` = 0, and are 0 after every other compare:
  - E is 1 when result bits 35:31 are not all equal.
  - U is 1 when result bits 31 and 30 are equal.
- R10: The flags change on the clock edge that samples `valid_i` = 1. When `valid_i` = 0 they hold.
- R11: A synchronous reset `rst` clears all six flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Issues a compare this cycle |
| size_i | input | 2 | Data size: 0 byte, 1 word, 2 long, 3 full |
| use_reg_i | input | 1 | Take the source from `src_reg_i` |
| compat_i | input | 1 | Ignore the extension on full compares |
| dst_acc_i | input | 36 | Destination accumulator |
| src_acc_i | input | 36 | Source accumulator |
| src_reg_i | input | 16 | Source register |
| flag_e_o | output | 1 | Extension in use |
| flag_u_o | output | 1 | Unnormalized |
| flag_n_o | output | 1 | Negative |
| flag_z_o | output | 1 | Zero |
| flag_v_o | output | 1 | Overflow |
| flag_c_o | output | 1 | Borrow |

## Verification
The assertions check these relations on every cycle:
- flags hold while no compare is issued;
- E and U are clear after any compare that is not a normal-mode full compare;
- Z is never set together with N;
- equal operands give Z with no borrow or overflow, and a long or compat-mode full compare ignores differences confined to the extension.

The actual flag values need the bench's scenarios:
- the overflow and borrow corners at each width;
- the placement of a register source;
- the E and U boundaries on bits 35 to 30;
- the flags after a reset.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

    localparam int ACC_W  = 36;
    localparam int EXT_W  = 4;
    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int LONG_W = ACC_W - EXT_W;
    localparam int N_SIZE = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_FULL = 2'd3
    } cmp_size_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } arith_flags_t;

    typedef struct packed {
        logic         e;
        logic         u;
        arith_flags_t a;
    } cc_flags_t;

    // Width in bits of a size code
    function automatic int size_width(input int idx);
        case (idx)
            0:       return BYTE_W;
            1:       return WORD_W;
            2:       return LONG_W;
            default: return ACC_W;
        endcase
    endfunction

    // Extension and top body bit disagree
    function automatic logic ext_in_use(input logic [ACC_W-1:0] r);
        return !((&r[ACC_W-1:LONG_W-1]) || !(|r[ACC_W-1:LONG_W-1]));
    endfunction

    // Two top body bits agree
    function automatic logic unnormalized(input logic [ACC_W-1:0] r);
        return r[LONG_W-1] == r[LONG_W-2];
    endfunction

endpackage

// File: rtl/cmp_operand_align.sv
module cmp_operand_align
    import cmp_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int EW = EXT_W,
    parameter int RW = REG_W
) (
    input  cmp_size_e         size,
    input  logic              use_reg,
    input  logic [AW-1:0]     dst_acc,
    input  logic [AW-1:0]     src_acc,
    input  logic [RW-1:0]     src_reg,
    output logic [AW-1:0]     dst_op,
    output logic [AW-1:0]     src_op
);
    localparam int BODY_W = AW - EW;
    localparam int PAD_W  = BODY_W - RW;

    logic [AW-1:0] reg_low;
    logic [AW-1:0] reg_high;

    assign reg_low  = {{(AW-RW){src_reg[RW-1]}}, src_reg};
    assign reg_high = {{EW{src_reg[RW-1]}}, src_reg, {PAD_W{1'b0}}};
    assign dst_op   = dst_acc;

    always_comb begin
        if (!use_reg)
            src_op = src_acc;
        else if (size == SZ_BYTE || size == SZ_WORD)
            src_op = reg_low;
        else
            src_op = reg_high;
    end

endmodule

// File: rtl/cmp_subtract.sv
module cmp_subtract
    import cmp_pkg::*;
#(
    parameter int AW = ACC_W
) (
    input  logic [AW-1:0] a,
    input  logic [AW-1:0] b,
    output logic [AW:0]   a_x,
    output logic [AW:0]   b_x,
    output logic [AW:0]   diff
);
    assign a_x  = {1'b0, a};
    assign b_x  = {1'b0, b};
    assign diff = a_x - b_x;
endmodule

// File: rtl/cmp_width_tap.sv
module cmp_width_tap
    import cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [1:0]   a_top,   // a[W:W-1]
    input  logic [1:0]   b_top,   // b[W:W-1]
    input  logic [W:0]   d,       // shared difference, bits W:0
    output arith_flags_t flags
);
    assign flags.n = d[W-1];
    assign flags.z = ~|d[W-1:0];
    assign flags.v = (a_top[0] ^ b_top[0]) & (a_top[0] ^ d[W-1]);
    assign flags.c = a_top[1] ^ b_top[1] ^ d[W];
endmodule

// File: rtl/cc_compare_unit.sv
module cc_compare_unit
    import cmp_pkg::*;
#(
    parameter int AW = ACC_W,
    parameter int EW = EXT_W,
    parameter int RW = REG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_i,
    input  logic [1:0]    size_i,
    input  logic          use_reg_i,
    input  logic          compat_i,
    input  logic [AW-1:0] dst_acc_i,
    input  logic [AW-1:0] src_acc_i,
    input  logic [RW-1:0] src_reg_i,
    output logic          flag_e_o,
    output logic          flag_u_o,
    output logic          flag_n_o,
    output logic          flag_z_o,
    output logic          flag_v_o,
    output logic          flag_c_o
);
    cmp_size_e     size;
    logic [AW-1:0] dst_op, src_op;
    logic [AW:0]   a_x, b_x, diff;
    arith_flags_t  tap_flags [N_SIZE];
    logic [1:0]    sel;
    logic          ext_mode;
    cc_flags_t     nxt_flags, cur_flags;

    assign size = cmp_size_e'(size_i);

    cmp_operand_align #(.AW(AW), .EW(EW), .RW(RW)) u_align (
        .size    (size),
        .use_reg (use_reg_i),
        .dst_acc (dst_acc_i),
        .src_acc (src_acc_i),
        .src_reg (src_reg_i),
        .dst_op  (dst_op),
        .src_op  (src_op)
    );

    cmp_subtract #(.AW(AW)) u_sub (
        .a    (dst_op),
        .b    (src_op),
        .a_x  (a_x),
        .b_x  (b_x),
        .diff (diff)
    );

    // One flag tap per data size, all sharing the single subtractor
    for (genvar g = 0; g < N_SIZE; g++) begin : g_tap
        localparam int W = (g == N_SIZE-1) ? AW : size_width(g);
        cmp_width_tap #(.W(W)) u_tap (
            .a_top (a_x[W:W-1]),
            .b_top (b_x[W:W-1]),
            .d     (diff[W:0]),
            .flags (tap_flags[g])
        );
    end

    assign ext_mode = (size == SZ_FULL) && !compat_i;

    always_comb begin
        case (size)
            SZ_BYTE: sel = 2'd0;
            SZ_WORD: sel = 2'd1;
            SZ_LONG: sel = 2'd2;
            default: sel = compat_i ? 2'd2 : 2'd3;
        endcase
    end

    always_comb begin
        nxt_flags.a = tap_flags[sel];
        nxt_flags.e = ext_mode & ext_in_use(diff[AW-1:0]);
        nxt_flags.u = ext_mode & unnormalized(diff[AW-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_flags <= '0;
        else if (valid_i)
            cur_flags <= nxt_flags;
    end

    assign flag_e_o = cur_flags.e;
    assign flag_u_o = cur_flags.u;
    assign flag_n_o = cur_flags.a.n;
    assign flag_z_o = cur_flags.a.z;
    assign flag_v_o = cur_flags.a.v;
    assign flag_c_o = cur_flags.a.c;

endmodule

// File: rtl/cmp_checker.sv
module cmp_checker #(
    parameter int AW = 36
) (
    input logic          clk,
    input logic          rst,
    input logic          valid_i,
    input logic [1:0]    size_i,
    input logic          use_reg_i,
    input logic          compat_i,
    input logic [AW-1:0] dst_acc_i,
    input logic [AW-1:0] src_acc_i,
    input logic          flag_e_o,
    input logic          flag_u_o,
    input logic          flag_n_o,
    input logic          flag_z_o,
    input logic          flag_v_o,
    input logic          flag_c_o
);
    logic [5:0] fl;
    assign fl = {flag_e_o, flag_u_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o};

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(fl));

    assert_ext_clear_R9: assert property (@(posedge clk) disable iff (rst)
        valid_i && (size_i != 2'd3 || compat_i) |=> !flag_e_o && !flag_u_o);

    assert_equal_zero_R7: assert property (@(posedge clk) disable iff (rst)
        valid_i && !use_reg_i && dst_acc_i == src_acc_i
        |=> flag_z_o && !flag_n_o && !flag_v_o && !flag_c_o);

    assert_zero_not_neg_R7: assert property (@(posedge clk) disable iff (rst)
        flag_z_o |-> !flag_n_o);

    assert_long_no_ext_R4: assert property (@(posedge clk) disable iff (rst)
        valid_i && size_i == 2'd2 && !use_reg_i && dst_acc_i[31:0] == src_acc_i[31:0]
        |=> flag_z_o);

    assert_compat_no_ext_R8: assert property (@(posedge clk) disable iff (rst)
        valid_i && size_i == 2'd3 && compat_i && !use_reg_i
        && dst_acc_i[31:0] == src_acc_i[31:0] |=> flag_z_o && !flag_e_o);

endmodule

bind cc_compare_unit cmp_checker #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_i   (valid_i),
    .size_i    (size_i),
    .use_reg_i (use_reg_i),
    .compat_i  (compat_i),
    .dst_acc_i (dst_acc_i),
    .src_acc_i (src_acc_i),
    .flag_e_o  (flag_e_o),
    .flag_u_o  (flag_u_o),
    .flag_n_o  (flag_n_o),
    .flag_z_o  (flag_z_o),
    .flag_v_o  (flag_v_o),
    .flag_c_o  (flag_c_o)
);

// File: tb/cc_compare_unit_tb.sv
module cc_compare_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [1:0]  size_i = '0;
    logic        use_reg_i = 1'b0;
    logic        compat_i = 1'b0;
    logic [35:0] dst_acc_i = '0;
    logic [35:0] src_acc_i = '0;
    logic [15:0] src_reg_i = '0;
    logic flag_e_o, flag_u_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o;

    int vectors = 0;
    int miscompares = 0;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;

    item_t      sb_q[$];
    logic [5:0] last_exp = '0;

    always #5 clk = ~clk;

    cc_compare_unit u_dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .size_i(size_i),
        .use_reg_i(use_reg_i), .compat_i(compat_i),
        .dst_acc_i(dst_acc_i), .src_acc_i(src_acc_i), .src_reg_i(src_reg_i),
        .flag_e_o(flag_e_o), .flag_u_o(flag_u_o), .flag_n_o(flag_n_o),
        .flag_z_o(flag_z_o), .flag_v_o(flag_v_o), .flag_c_o(flag_c_o)
    );

    function automatic logic [5:0] dut_flags();
        return {flag_e_o, flag_u_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o};
    endfunction

    // Reference model built from the requirements; returns {E,U,N,Z,V,C}
    function automatic logic [5:0] model(logic [1:0] sz, logic ur, logic cm,
                                         logic [35:0] dst, logic [35:0] src,
                                         logic [15:0] rg);
        logic [35:0] b;
        longint unsigned mask, ua, ub, df;
        logic [35:0] full;
        int w;
        logic n, z, v, c, sa, sb, e, u, ext;
        if (!ur)          b = src;
        else if (sz < 2)  b = {{20{rg[15]}}, rg};          // R2/R3
        else              b = {{4{rg[15]}}, rg, 16'h0};    // R6
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : (sz == 2 || cm) ? 32 : 36;
        mask = (64'd1 << w) - 1;
        ua = 64'(dst) & mask;
        ub = 64'(b) & mask;
        df = (ua - ub) & mask;
        n  = df[w-1];
        z  = (df == 0);
        c  = (ua < ub);
        sa = ua[w-1];
        sb = ub[w-1];
        v  = (sa != sb) && (n != sa);
        full = dst - b;
        ext  = (sz == 3) && !cm;
        e = ext && !(full[35:31] == 5'h00 || full[35:31] == 5'h1f);
        u = ext && (full[31] == full[30]);
        return {e, u, n, z, v, c};
    endfunction

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: flags EUNZVC act=%b exp=%b", tag, act, exp);
        end
    endtask

    // Driver: puts one compare on the inputs and queues its expected flags
    task automatic issue(logic [1:0] sz, logic ur, logic cm, logic [35:0] dst,
                         logic [35:0] src, logic [15:0] rg, string tag);
        item_t it;
        @(negedge clk);
        valid_i = 1'b1; size_i = sz; use_reg_i = ur; compat_i = cm;
        dst_acc_i = dst; src_acc_i = src; src_reg_i = rg;
        it.exp = model(sz, ur, cm, dst, src, rg);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic idle(int n);
        @(negedge clk);
        valid_i = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pops one expected item per sampled strobe
    always @(posedge clk) begin
        if (!rst && valid_i) begin
            #2;
            if (sb_q.size() == 0) begin
                check("R10 queue empty", dut_flags(), 6'bx);
            end else begin
                item_t it;
                it = sb_q.pop_front();
                last_exp = it.exp;
                check(it.tag, dut_flags(), it.exp);
            end
        end
    end

    initial begin
        #(10 * 150000);
        miscompares++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset", dut_flags(), 6'b0);
        rst = 1'b0;

        // Byte and word corners (R2, R3, R7)
        issue(0, 0, 0, 36'h0_0000_0080, 36'h0_0000_0001, 16'h0, "R2 byte overflow");
        issue(0, 0, 0, 36'hF_FFFF_FF12, 36'h0_0000_0012, 16'h0, "R2 byte upper ignored");
        issue(0, 1, 0, 36'h0_0000_0005, 36'h0, 16'h0007, "R2 byte reg source");
        issue(1, 0, 0, 36'h0_0000_0000, 36'h0_0000_0001, 16'h0, "R3 word borrow");
        issue(1, 0, 0, 36'h0_0000_8000, 36'h0_0000_0001, 16'h0, "R3 word overflow");
        issue(1, 1, 0, 36'h0_0000_1234, 36'h0, 16'h1234, "R3 word reg equal");
        // Long and full (R4, R5, R7)
        issue(2, 0, 0, 36'h5_1234_5678, 36'hA_1234_5678, 16'h0, "R4 long ext ignored");
        issue(2, 0, 0, 36'h0_8000_0000, 36'h0_0000_0001, 16'h0, "R4 long overflow");
        issue(3, 0, 0, 36'h5_1234_5678, 36'hA_1234_5678, 16'h0, "R5 full ext used");
        issue(3, 0, 0, 36'h7_FFFF_FFFF, 36'hF_FFFF_FFFF, 16'h0, "R5 full overflow");
        issue(1, 0, 0, 36'h0_0000_0080, 36'h0_0000_0001, 16'h0, "R1 same bits word");
        // Register source aligned high (R6)
        issue(2, 1, 0, 36'h0_8001_0000, 36'h0, 16'h8001, "R6 long reg equal");
        issue(3, 1, 0, 36'hF_8001_0000, 36'h0, 16'h8001, "R6 full reg sign ext");
        issue(3, 1, 0, 36'h0_8001_0000, 36'h0, 16'h8001, "R6 full reg ext differs");
        // E and U (R9)
        issue(3, 0, 0, 36'h0_8000_0000, 36'h0, 16'h0, "R9 E set");
        issue(3, 0, 0, 36'h0_2000_0000, 36'h0, 16'h0, "R9 U set");
        issue(3, 0, 0, 36'hF_C000_0000, 36'h0, 16'h0, "R9 U set negative");
        issue(3, 0, 0, 36'h0_4000_0000, 36'h0, 16'h0, "R9 E U clear");
        issue(2, 0, 0, 36'h0_8000_0000, 36'h0, 16'h0, "R9 long no E");
        // Compatibility mode (R8)
        issue(3, 0, 1, 36'h5_1234_5678, 36'hA_1234_5678, 16'h0, "R8 compat ext ignored");
        issue(3, 0, 1, 36'h0_8000_0000, 36'h0, 16'h0, "R8 compat no E");
        issue(3, 0, 1, 36'h0_8000_0000, 36'h0_0000_0001, 16'h0, "R8 compat overflow 32");

        // Hold with changing inputs (R10)
        issue(0, 0, 0, 36'h0_0000_0000, 36'h0_0000_0001, 16'h0, "R10 setup");
        @(negedge clk);
        valid_i = 1'b0; size_i = 3; dst_acc_i = 36'h0_1234_0000; src_acc_i = 36'h0;
        repeat (3) @(negedge clk);
        check("R10 hold", dut_flags(), last_exp);

        // Mixed random vectors
        for (int i = 0; i < 64; i++) begin
            logic [1:0]  sz;
            logic [35:0] d, s;
            sz = 2'($urandom % 4);
            d  = {4'($urandom), 32'($urandom)};
            s  = ($urandom % 5 == 0) ? d ^ 36'hF_0000_0000 : {4'($urandom), 32'($urandom)};
            issue(sz, 1'($urandom), 1'($urandom), d, s, 16'($urandom),
                  sz == 0 ? "R2 random" : sz == 1 ? "R3 random" :
                  sz == 2 ? "R4 random" : "R5 random");
        end
        idle(2);
        check("R10 queue drained", 6'(sb_q.size()), 6'd0);

        // Mid-run reset (R11)
        issue(3, 0, 0, 36'h0_8000_0000, 36'h0_0000_0001, 16'h0, "R11 pre-reset");
        @(negedge clk);
        valid_i = 1'b0; rst = 1'b1;
        @(negedge clk);
        check("R11 mid reset", dut_flags(), 6'b0);
        rst = 1'b0;
        idle(1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule